// File: doc/BRIEF.md
# Adaptive Parameter Threshold Monitor

This block watches a set of adapted receiver parameters and flags any that drift out of a programmed window. Each primary parameter class (five by default) has a high and a low threshold. One wide class, the variance sum, has only a high threshold. Whenever the sample strobe fires while monitoring is active, every parameter is compared against its thresholds. Each violation latches a warning bit and raises one shared interrupt line. Monitoring is active only when the enable is set and the link is valid.

Software sees the warnings through two status words. Reading either word clears that word's warnings. Only a read of the primary word drops the interrupt and re-arms it. Each parameter class also has a restart enable. A violation in an enabled class sends a one-cycle restart request to the adaptation logic. When the signal-detect option bit is 0, the same violation also sends a link-drop request. Threshold storage sits outside the block, and the thresholds arrive as flat input buses.

Top module: `lq_monitor`

## Requirements
- R1: No warning bit is set while the monitor enable or the link-valid input is low, even if the strobe fires with out-of-window values.
- R2: On a strobe with monitoring active, the high warning of class k is set on the next clock if the value is strictly greater than the class's high threshold. The low warning is set if the value is strictly less than the low threshold. A value equal to a threshold sets nothing. In warn_pri_o, bit 2k is the low warning of class k and bit 2k+1 is its high warning. Class k occupies bits [16k+15:16k] of the parameter and threshold buses. All comparisons are unsigned.
- R3: A high threshold of all ones, or a low threshold of zero, never produces a warning.
- R4: A primary read clears warn_pri_o on the next clock. A violation in the same cycle as the read stays set.
- R5: The variance high warning (warn_sec_o) is set when the variance is strictly greater than its threshold. A secondary read clears warn_sec_o but leaves irq_o and warn_pri_o unchanged.
- R6: irq_o rises on the clock after any primary or variance violation.
- R7: Once raised, irq_o stays high until a primary read with no violation in the same cycle. New violations keep setting warning bits in the meantime.
- R8: restart_o pulses for one cycle, on the clock after a violation in a class whose restart enable is set. A violation in a class whose restart enable is clear causes no pulse. Bit k of rst_en_i enables class k, and var_rst_en_i enables the variance class.
- R9: link_drop_o pulses together with restart_o only when sd_opt_i was 0 in the violation cycle. It never pulses without restart_o.
- R10: After reset all warnings, irq_o, restart_o and link_drop_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mon_en_i | input | 1 | Monitor enable |
| link_ok_i | input | 1 | Valid link present |
| smp_vld_i | input | 1 | Parameter sample strobe |
| par_i | input | N_CLS*PW | Primary parameter values, class k at [PW*k +: PW] |
| thr_hi_i | input | N_CLS*PW | High thresholds |
| thr_lo_i | input | N_CLS*PW | Low thresholds |
| var_i | input | VW | Variance sum |
| var_thr_hi_i | input | VW | Variance high threshold |
| rst_en_i | input | N_CLS | Restart enable per primary class |
| var_rst_en_i | input | 1 | Restart enable for variance |
| sd_opt_i | input | 1 | Signal-detect option; 0 adds a link drop to each restart |
| rd_pri_i | input | 1 | Primary status read strobe |
| rd_sec_i | input | 1 | Secondary status read strobe |
| warn_pri_o | output | 2*N_CLS | Primary warnings, {hi,lo} per class |
| warn_sec_o | output | 1 | Variance high warning |
| irq_o | output | 1 | Interrupt |
| restart_o | output | 1 | Restart request pulse |
| link_drop_o | output | 1 | Link-drop request pulse |

## Verification
Two events can land in the same cycle: a status read that clears warnings, and a strobe that produces a new violation. The bench first leaves an older warning set. It then asserts the primary read and a strobe with a new out-of-window value on the same clock. The expected result is that the older bit clears, the new bit survives and the interrupt stays high. A matching case pairs a secondary read with a pending interrupt. That case checks that the variance warning clears while irq_o does not move.

// File: rtl/lqm_pkg.sv
package lqm_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } lqm_viol_t;
endpackage

// File: rtl/lqm_cmp.sv
module lqm_cmp #(
  parameter int W = 16
) (
  input  logic         chk_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] thr_hi_i,
  input  logic [W-1:0] thr_lo_i,
  output lqm_pkg::lqm_viol_t viol_o
);
  // strict compares: all-ones high / zero low disables the limit
  always_comb begin
    viol_o.hi = chk_i && (val_i > thr_hi_i);
    viol_o.lo = chk_i && (val_i < thr_lo_i);
  end
endmodule

// File: rtl/lqm_warn.sv
module lqm_warn #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  output logic [N-1:0] warn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warn_o <= '0;
    else         warn_o <= (rd_i ? '0 : warn_o) | set_i;  // set wins over clear
  end
endmodule

// File: rtl/lqm_event.sv
module lqm_event #(
  parameter int NC = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NC-1:0] cls_viol_i,
  input  logic [NC-1:0] rst_en_i,
  input  logic          sd_opt_i,
  input  logic          rd_pri_i,
  output logic          irq_o,
  output logic          restart_o,
  output logic          link_drop_o
);
  logic any_viol, rst_req;

  assign any_viol = |cls_viol_i;
  assign rst_req  = |(cls_viol_i & rst_en_i);

  // irq high == disarmed; only a primary read re-arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      restart_o   <= 1'b0;
      link_drop_o <= 1'b0;
    end else begin
      irq_o       <= any_viol | (irq_o & ~rd_pri_i);
      restart_o   <= rst_req;
      link_drop_o <= rst_req & ~sd_opt_i;
    end
  end
endmodule

// File: rtl/lq_monitor.sv
module lq_monitor #(
  parameter int N_CLS = 5,
  parameter int PW    = 16,
  parameter int VW    = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mon_en_i,
  input  logic               link_ok_i,
  input  logic               smp_vld_i,
  input  logic [N_CLS*PW-1:0] par_i,
  input  logic [N_CLS*PW-1:0] thr_hi_i,
  input  logic [N_CLS*PW-1:0] thr_lo_i,
  input  logic [VW-1:0]      var_i,
  input  logic [VW-1:0]      var_thr_hi_i,
  input  logic [N_CLS-1:0]   rst_en_i,
  input  logic               var_rst_en_i,
  input  logic               sd_opt_i,
  input  logic               rd_pri_i,
  input  logic               rd_sec_i,
  output logic [2*N_CLS-1:0] warn_pri_o,
  output logic               warn_sec_o,
  output logic               irq_o,
  output logic               restart_o,
  output logic               link_drop_o
);
  localparam int NW = 2 * N_CLS;
  localparam int NC = N_CLS + 1;

  logic               chk;
  logic [NW-1:0]      pri_set;
  logic [N_CLS-1:0]   pri_cls;
  logic               sec_set;
  lqm_pkg::lqm_viol_t var_v;

  assign chk = smp_vld_i & mon_en_i & link_ok_i;

  for (genvar k = 0; k < N_CLS; k++) begin : g_cls
    lqm_pkg::lqm_viol_t v;
    lqm_cmp #(.W(PW)) u_cmp (
      .chk_i    (chk),
      .val_i    (par_i[k*PW +: PW]),
      .thr_hi_i (thr_hi_i[k*PW +: PW]),
      .thr_lo_i (thr_lo_i[k*PW +: PW]),
      .viol_o   (v)
    );
    assign pri_set[2*k]   = v.lo;
    assign pri_set[2*k+1] = v.hi;
    assign pri_cls[k]     = v.hi | v.lo;
  end

  // variance: high limit only, low compare pinned off by a zero threshold
  lqm_cmp #(.W(VW)) u_var_cmp (
    .chk_i    (chk),
    .val_i    (var_i),
    .thr_hi_i (var_thr_hi_i),
    .thr_lo_i ('0),
    .viol_o   (var_v)
  );
  assign sec_set = var_v.hi | var_v.lo;

  lqm_warn #(.N(NW)) u_warn_pri (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pri_set),
    .rd_i   (rd_pri_i),
    .warn_o (warn_pri_o)
  );

  lqm_warn #(.N(1)) u_warn_sec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sec_set),
    .rd_i   (rd_sec_i),
    .warn_o (warn_sec_o)
  );

  lqm_event #(.NC(NC)) u_event (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cls_viol_i  ({sec_set, pri_cls}),
    .rst_en_i    ({var_rst_en_i, rst_en_i}),
    .sd_opt_i    (sd_opt_i),
    .rd_pri_i    (rd_pri_i),
    .irq_o       (irq_o),
    .restart_o   (restart_o),
    .link_drop_o (link_drop_o)
  );
endmodule

// File: rtl/lq_monitor_chk.sv
module lq_monitor_chk #(
  parameter int N_CLS = 5,
  parameter int PW    = 16,
  parameter int VW    = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mon_en_i,
  input logic               link_ok_i,
  input logic               smp_vld_i,
  input logic [N_CLS*PW-1:0] par_i,
  input logic [N_CLS*PW-1:0] thr_hi_i,
  input logic [N_CLS*PW-1:0] thr_lo_i,
  input logic [VW-1:0]      var_i,
  input logic [VW-1:0]      var_thr_hi_i,
  input logic [N_CLS-1:0]   rst_en_i,
  input logic               var_rst_en_i,
  input logic               sd_opt_i,
  input logic               rd_pri_i,
  input logic               rd_sec_i,
  input logic [2*N_CLS-1:0] warn_pri_o,
  input logic               warn_sec_o,
  input logic               irq_o,
  input logic               restart_o,
  input logic               link_drop_o
);
  logic             act;
  logic [N_CLS-1:0] hi_x, lo_x;
  logic             var_x, any_x, rst_x;

  assign act = smp_vld_i && mon_en_i && link_ok_i;

  always_comb begin
    for (int k = 0; k < N_CLS; k++) begin
      hi_x[k] = act && (par_i[k*PW +: PW] > thr_hi_i[k*PW +: PW]);
      lo_x[k] = act && (par_i[k*PW +: PW] < thr_lo_i[k*PW +: PW]);
    end
  end
  assign var_x = act && (var_i > var_thr_hi_i);
  assign any_x = var_x || (|hi_x) || (|lo_x);
  assign rst_x = (var_x && var_rst_en_i) || (|((hi_x | lo_x) & rst_en_i));

  p_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mon_en_i && link_ok_i) |=> ((warn_pri_o & ~$past(warn_pri_o)) == '0));

  for (genvar k = 0; k < N_CLS; k++) begin : g_a
    p_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_x[k] |=> warn_pri_o[2*k+1]);
    p_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lo_x[k] |=> warn_pri_o[2*k]);
  end

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pri_i && !smp_vld_i) |=> (warn_pri_o == '0));

  p_sec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sec_i && !smp_vld_i) |=> !warn_sec_o);

  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_x |=> irq_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_pri_i) |=> irq_o);

  p_rearm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pri_i && !any_x) |=> !irq_o);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_x |=> restart_o);

  p_norestart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_x |=> !restart_o);

  p_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_x && !sd_opt_i) |=> link_drop_o);

  p_dropsub_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_drop_o |-> restart_o);
endmodule

bind lq_monitor lq_monitor_chk #(.N_CLS(N_CLS), .PW(PW), .VW(VW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mon_en_i(mon_en_i), .link_ok_i(link_ok_i),
  .smp_vld_i(smp_vld_i), .par_i(par_i), .thr_hi_i(thr_hi_i), .thr_lo_i(thr_lo_i),
  .var_i(var_i), .var_thr_hi_i(var_thr_hi_i), .rst_en_i(rst_en_i),
  .var_rst_en_i(var_rst_en_i), .sd_opt_i(sd_opt_i), .rd_pri_i(rd_pri_i),
  .rd_sec_i(rd_sec_i), .warn_pri_o(warn_pri_o), .warn_sec_o(warn_sec_o),
  .irq_o(irq_o), .restart_o(restart_o), .link_drop_o(link_drop_o)
);

// File: tb/lq_monitor_bench.sv
module lq_monitor_bench;
  localparam int N_CLS = 5;
  localparam int PW    = 16;
  localparam int VW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_en, link_ok, vld, sd_opt, rd_pri, rd_sec, var_rst_en;
  logic [N_CLS*PW-1:0] par, thr_hi, thr_lo;
  logic [VW-1:0] var_v, var_thr;
  logic [N_CLS-1:0] rst_en;
  logic [2*N_CLS-1:0] warn_pri;
  logic warn_sec, irq, restart, link_drop;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  lq_monitor #(.N_CLS(N_CLS), .PW(PW), .VW(VW)) u_lq_monitor (
    .clk_i(clk), .rst_ni(rst_n), .mon_en_i(mon_en), .link_ok_i(link_ok),
    .smp_vld_i(vld), .par_i(par), .thr_hi_i(thr_hi), .thr_lo_i(thr_lo),
    .var_i(var_v), .var_thr_hi_i(var_thr), .rst_en_i(rst_en),
    .var_rst_en_i(var_rst_en), .sd_opt_i(sd_opt), .rd_pri_i(rd_pri),
    .rd_sec_i(rd_sec), .warn_pri_o(warn_pri), .warn_sec_o(warn_sec),
    .irq_o(irq), .restart_o(restart), .link_drop_o(link_drop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_par(input int k, input logic [PW-1:0] v);
    par[k*PW +: PW] = v;
  endtask

  task automatic defaults();
    for (int k = 0; k < N_CLS; k++) begin
      par[k*PW +: PW]    = 16'h4000;
      thr_hi[k*PW +: PW] = 16'h8000;
      thr_lo[k*PW +: PW] = 16'h1000;
    end
    var_v = 32'h100; var_thr = 32'h1_0000;
  endtask

  // strobe with inputs already set; outputs valid at return
  task automatic strobe(input logic with_rd_pri = 1'b0);
    @(negedge clk); vld = 1'b1; rd_pri = with_rd_pri;
    @(negedge clk); vld = 1'b0; rd_pri = 1'b0;
  endtask

  task automatic read(input logic p, input logic s);
    @(negedge clk); rd_pri = p; rd_sec = s;
    @(negedge clk); rd_pri = 1'b0; rd_sec = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 warn_pri", 32'(warn_pri), 0);
    chk("R10 warn_sec", 32'(warn_sec), 0);
    chk("R10 irq", 32'(irq), 0);
    chk("R10 restart/drop", {30'b0, restart, link_drop}, 0);
  endtask

  task automatic t_gate();
    mon_en = 1'b0; set_par(2, 16'h9000);
    strobe();
    chk("R1 disabled warn", 32'(warn_pri), 0);
    chk("R1 disabled irq", 32'(irq), 0);
    mon_en = 1'b1; link_ok = 1'b0;
    strobe();
    chk("R1 no link warn", 32'(warn_pri), 0);
    link_ok = 1'b1; defaults();
  endtask

  task automatic t_hi_lo();
    set_par(2, 16'h9000); set_par(0, 16'h0800);
    strobe();
    chk("R2 hi/lo bits", 32'(warn_pri), 32'h21);
    chk("R6 irq", 32'(irq), 1);
    chk("R5 sec untouched", 32'(warn_sec), 0);
    defaults();
    read(1'b1, 1'b0);
    chk("R4 read clears", 32'(warn_pri), 0);
    chk("R7 read rearms", 32'(irq), 0);
  endtask

  task automatic t_bounds();
    set_par(3, 16'h8000); set_par(1, 16'h1000);
    strobe();
    chk("R2 equal no warn", 32'(warn_pri), 0);
    thr_hi[4*PW +: PW] = 16'hFFFF; set_par(4, 16'hFFFF);
    strobe();
    chk("R3 max high", 32'(warn_pri), 0);
    thr_lo[4*PW +: PW] = 16'h0000; set_par(4, 16'h0000);
    strobe();
    chk("R3 min low", 32'(warn_pri), 0);
    chk("R3 irq quiet", 32'(irq), 0);
    defaults();
  endtask

  task automatic t_sticky();
    set_par(1, 16'h9000);
    strobe();
    chk("R2 class1 hi", 32'(warn_pri), 32'h08);
    repeat (3) @(negedge clk);
    chk("R7 irq held", 32'(irq), 1);
    defaults(); set_par(3, 16'h0000);
    strobe();
    chk("R7 warn while disarmed", 32'(warn_pri), 32'h48);
    defaults();
    read(1'b1, 1'b0);
    chk("R4 cleared", 32'(warn_pri), 0);
    chk("R7 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_same();
    set_par(0, 16'h0800);
    strobe();
    defaults(); set_par(2, 16'h9000);
    strobe(1'b1);
    chk("R4 same-cycle kept", 32'(warn_pri), 32'h20);
    chk("R7 irq stays", 32'(irq), 1);
    defaults();
    read(1'b1, 1'b0);
  endtask

  task automatic t_sec();
    var_v = 32'h1_0000;
    strobe();
    chk("R5 equal no warn", 32'(warn_sec), 0);
    var_v = 32'h2_0000;
    strobe();
    chk("R5 var warn", 32'(warn_sec), 1);
    chk("R6 var irq", 32'(irq), 1);
    defaults();
    read(1'b0, 1'b1);
    chk("R5 sec read clears", 32'(warn_sec), 0);
    chk("R5 irq kept", 32'(irq), 1);
    read(1'b1, 1'b0);
    chk("R7 primary rearm", 32'(irq), 0);
  endtask

  task automatic t_restart();
    rst_en = 5'b00010; sd_opt = 1'b1; set_par(1, 16'h9000);
    strobe();
    chk("R8 restart", 32'(restart), 1);
    chk("R9 no drop sd=1", 32'(link_drop), 0);
    @(negedge clk);
    chk("R8 one pulse", 32'(restart), 0);
    sd_opt = 1'b0;
    strobe();
    chk("R9 drop sd=0", {30'b0, restart, link_drop}, 3);
    defaults(); set_par(4, 16'h9000);
    strobe();
    chk("R8 disabled class", {30'b0, restart, link_drop}, 0);
    defaults(); var_rst_en = 1'b1; var_v = 32'h2_0000;
    strobe();
    chk("R8 variance restart", {30'b0, restart, link_drop}, 3);
    defaults(); rst_en = '0; var_rst_en = 1'b0; sd_opt = 1'b1;
    read(1'b1, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    mon_en = 1'b1; link_ok = 1'b1; vld = 1'b0; sd_opt = 1'b1;
    rd_pri = 1'b0; rd_sec = 1'b0; var_rst_en = 1'b0; rst_en = '0;
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_gate();
    t_hi_lo();
    t_bounds();
    t_sticky();
    t_same();
    t_sec();
    t_restart();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule